// File: doc/BRIEF.md
# Windowed Key-Serviced Watchdog

This block guards a processor against runaway code. Software keeps it alive by writing a 16-bit key (default 0x1984) to one service address on a simple write bus. The block stays idle until the first correct key write arrives. That write arms it and clears its tick counter. From then on, every service write must land inside a window centred on a nominal period and measured from the last accepted service.

A service write that comes too early is a fault, and so is one that comes too late. A wrong value written to the service address is a fault. Letting the counter run out with no service at all is also a fault. Any fault drives a hardware reset pulse of fixed length and latches a 2-bit code naming the fault. When the pulse ends, the block returns to the unarmed state, and the next key write arms it again.

The counter advances only on cycles where the tick enable is high, so the period, delta and timeout are all counted in ticks. Once the block is armed, no bus write can turn it off.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset, `rst_o` is 0, `cause_o` is 2'b00 and the block is unarmed. While unarmed it never asserts `rst_o`, however long it runs.
- R2: A write of KEY to SVC_ADDR while unarmed arms the block with its counter at zero. While unarmed, writes of any other value, and writes to any other address, are ignored.
- R3: While armed, a KEY write at SVC_ADDR is accepted when the counter is between PERIOD-DELTA and PERIOD+DELTA, both ends included. An accepted write restarts the counter from zero and causes no reset.
- R4: While armed, a KEY write while the counter is below PERIOD-DELTA is an early fault and sets cause 2'b01.
- R5: While armed, a KEY write while the counter is above PERIOD+DELTA is a late fault and sets cause 2'b10.
- R6: While armed, when a tick arrives with the counter at TIMEOUT-1 and no service write, the block faults with cause 2'b00. Its reset starts in the next cycle.
- R7: While armed, a write of any value other than KEY to SVC_ADDR is a bad-key fault and sets cause 2'b11.
- R8: A fault raises `rst_o` in the cycle after the offending write or tick and holds it for exactly RST_CYC cycles. After that the block is unarmed, and `cause_o` keeps the fault code until the next fault. All four cause encodings are defined.
- R9: While armed, writes to addresses other than SVC_ADDR have no effect. They do not disarm the block or bite, and the block still times out afterwards.
- R10: The counter advances only on cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | Tick enable that advances the counter |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W | Bus write address |
| wdata_i | input | DATA_W | Bus write data |
| rst_o | output | 1 | Hardware reset pulse |
| cause_o | output | 2 | Latched fault code: 00 timeout, 01 early, 10 late, 11 bad key |

## Verification
The bench probes both edges of the service window: PERIOD-DELTA must be accepted and one tick below it must not, and PERIOD+DELTA must be accepted and one tick above it must not. An off-by-one comparator would either bite on a valid service or accept an invalid one. The bench also checks that the timeout fires on exactly the TIMEOUT-th tick. It holds the tick enable low for a long stretch to catch a counter that runs on the clock instead of the tick. Other checks aim at a block that stays armed after its own reset pulse, reacts to wrong keys while unarmed, or can be disarmed by writes to other addresses.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_BITE = 2'b10
    } wdt_st_e;

    typedef enum logic [1:0] {
        CZ_TIMEOUT = 2'b00,
        CZ_EARLY   = 2'b01,
        CZ_LATE    = 2'b10,
        CZ_BADKEY  = 2'b11
    } wdt_cause_e;
endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode #(
    parameter int                 ADDR_W   = 8,
    parameter int                 DATA_W   = 16,
    parameter logic [ADDR_W-1:0]  SVC_ADDR = 8'h3C,
    parameter logic [DATA_W-1:0]  KEY      = 16'h1984
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              svc_hit_o,
    output logic              key_ok_o
);
    // A hit is any write to the service address; the key match is separate
    assign svc_hit_o = wr_i && (addr_i == SVC_ADDR);
    assign key_ok_o  = (wdata_i == KEY);
endmodule

// File: rtl/wdt_window_cmp.sv
module wdt_window_cmp #(
    parameter int CNT_W   = 7,
    parameter int PERIOD  = 20,
    parameter int DELTA   = 4,
    parameter int TIMEOUT = 40
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             early_o,
    output logic             late_o,
    output logic             last_o
);
    localparam int WIN_LO = PERIOD - DELTA;
    localparam int WIN_HI = PERIOD + DELTA;

    assign early_o = cnt_i < CNT_W'(WIN_LO);
    assign late_o  = cnt_i > CNT_W'(WIN_HI);
    assign last_o  = cnt_i == CNT_W'(TIMEOUT - 1);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int                 ADDR_W   = 8,
    parameter int                 DATA_W   = 16,
    parameter logic [ADDR_W-1:0]  SVC_ADDR = 8'h3C,
    parameter logic [DATA_W-1:0]  KEY      = 16'h1984,
    parameter int                 PERIOD   = 2000,
    parameter int                 DELTA    = 200,
    parameter int                 TIMEOUT  = 3000,
    parameter int                 RST_CYC  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rst_o,
    output logic [1:0]        cause_o
);
    localparam int CNT_W  = $clog2(TIMEOUT + 1);
    localparam int HOLD_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(RST_CYC - 1);

    typedef struct packed {
        wdt_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [HOLD_W-1:0] hold;
        wdt_cause_e        cause;
        logic              bite;
    } wdt_regs_t;

    wdt_regs_t q, d;

    logic svc_hit, key_ok;
    logic early, late, last;

    wdt_key_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .KEY(KEY)
    ) u_key (
        .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .svc_hit_o(svc_hit), .key_ok_o(key_ok)
    );

    wdt_window_cmp #(
        .CNT_W(CNT_W), .PERIOD(PERIOD), .DELTA(DELTA), .TIMEOUT(TIMEOUT)
    ) u_win (
        .cnt_i(q.cnt), .early_o(early), .late_o(late), .last_o(last)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                // Only a correct key arms; anything else is ignored
                if (svc_hit && key_ok) begin
                    d.st  = ST_RUN;
                    d.cnt = '0;
                end
            end
            ST_RUN: begin
                // A service write takes priority over a tick in the same cycle
                if (svc_hit) begin
                    if (!key_ok || early || late) begin
                        d.st   = ST_BITE;
                        d.hold = HOLD_INIT;
                        d.cnt  = '0;
                        if (!key_ok)    d.cause = CZ_BADKEY;
                        else if (early) d.cause = CZ_EARLY;
                        else            d.cause = CZ_LATE;
                    end else begin
                        d.cnt = '0;
                    end
                end else if (tick_i) begin
                    if (last) begin
                        d.st    = ST_BITE;
                        d.hold  = HOLD_INIT;
                        d.cnt   = '0;
                        d.cause = CZ_TIMEOUT;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_BITE: begin
                if (q.hold == '0) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end else begin
                    d.hold = q.hold - 1'b1;
                end
            end
            default: begin
                // Undefined encoding: fall into a full reset pulse
                d.st    = ST_BITE;
                d.hold  = HOLD_INIT;
                d.cnt   = '0;
                d.cause = CZ_TIMEOUT;
            end
        endcase
        d.bite = (d.st == ST_BITE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, cnt: '0, hold: '0, cause: CZ_TIMEOUT, bite: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rst_o   = q.bite;
    assign cause_o = q.cause;

    // Observation points for the bound checker
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    assign run_q = (q.st == ST_RUN);
    assign cnt_q = q.cnt;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int                 ADDR_W   = 8,
    parameter int                 DATA_W   = 16,
    parameter logic [ADDR_W-1:0]  SVC_ADDR = 8'h3C,
    parameter logic [DATA_W-1:0]  KEY      = 16'h1984,
    parameter int                 PERIOD   = 2000,
    parameter int                 DELTA    = 200,
    parameter int                 TIMEOUT  = 3000,
    parameter int                 RST_CYC  = 16,
    parameter int                 CNT_W    = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              rst_o,
    input logic [1:0]        cause_o,
    input logic              run_q,
    input logic [CNT_W-1:0]  cnt_q
);
    logic [31:0] hi_len;
    logic        key_wr;
    assign key_wr = run_q && wr_i && (addr_i == SVC_ADDR) && (wdata_i == KEY);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    hi_len <= '0;
        else if (rst_o) hi_len <= hi_len + 1;
        else            hi_len <= '0;
    end

    AST_UNARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_q && !rst_o) |=> !rst_o);                                          // R1
    AST_ACCEPT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_wr && cnt_q >= CNT_W'(PERIOD - DELTA) && cnt_q <= CNT_W'(PERIOD + DELTA))
        |=> (run_q && !rst_o && cnt_q == '0));                                   // R3
    AST_EARLY_BITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_wr && cnt_q < CNT_W'(PERIOD - DELTA)) |=> (rst_o && cause_o == 2'b01)); // R4
    AST_LATE_BITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_wr && cnt_q > CNT_W'(PERIOD + DELTA)) |=> (rst_o && cause_o == 2'b10)); // R5
    AST_TIMEOUT_BITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && tick_i && !wr_i && cnt_q == CNT_W'(TIMEOUT - 1))
        |=> (rst_o && cause_o == 2'b00));                                        // R6
    AST_BADKEY_BITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && wr_i && addr_i == SVC_ADDR && wdata_i != KEY)
        |=> (rst_o && cause_o == 2'b11));                                        // R7
    AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_o |-> (hi_len < RST_CYC));                                           // R8
    AST_OTHER_ADDR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && !tick_i && wr_i && addr_i != SVC_ADDR) |=> (run_q && !rst_o)); // R9
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && !tick_i && !wr_i) |=> (cnt_q == $past(cnt_q)));                // R10
endmodule

bind wdt_keyed wdt_keyed_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .KEY(KEY),
    .PERIOD(PERIOD), .DELTA(DELTA), .TIMEOUT(TIMEOUT), .RST_CYC(RST_CYC),
    .CNT_W(CNT_W)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rst_o(rst_o), .cause_o(cause_o),
    .run_q(run_q), .cnt_q(cnt_q)
);

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;
    localparam int          ADDR_W  = 8;
    localparam int          DATA_W  = 16;
    localparam logic [7:0]  SVC     = 8'h3C;
    localparam logic [15:0] KEY     = 16'h1984;
    localparam int          PERIOD  = 20;
    localparam int          DELTA   = 4;
    localparam int          TIMEOUT = 40;
    localparam int          RST_CYC = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b1;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              rst_o;
    logic [1:0]        cause_o;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_q[$];
    logic       prev_rst = 1'b0;
    int         pulse_len = 0;

    always #5 clk = ~clk;

    wdt_keyed #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC), .KEY(KEY),
        .PERIOD(PERIOD), .DELTA(DELTA), .TIMEOUT(TIMEOUT), .RST_CYC(RST_CYC)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rst_o(rst_o), .cause_o(cause_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // All driver tasks start and end at a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v);
        wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic expect_bite(input logic [1:0] c);
        exp_q.push_back(c);
    endtask

    task automatic wait_pulse_done();
        idle(RST_CYC + 2);
    endtask

    // Monitor: pops the expected cause on each rising reset pulse, times the pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (rst_o && !prev_rst) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected reset pulse", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check(cause_o == e, "R8 fault cause", int'(cause_o), int'(e));
                end
            end
            if (rst_o) pulse_len++;
            if (prev_rst && !rst_o) begin
                check(pulse_len == RST_CYC, "R8 pulse length", pulse_len, RST_CYC);
                pulse_len = 0;
            end
            prev_rst = rst_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        check(rst_o == 1'b0, "R1 reset rst_o", int'(rst_o), 0);
        check(cause_o == 2'b00, "R1 reset cause", int'(cause_o), 0);
        rst_n = 1'b1;
        idle(2);

        // R1/R2: unarmed, wrong values and wrong addresses are ignored
        idle(60);
        bus_write(SVC, 16'h1985);
        bus_write(8'h3D, KEY);
        bus_write(SVC, 16'h0000);
        idle(TIMEOUT + 20);
        check(rst_o == 1'b0, "R1 unarmed stays quiet", int'(rst_o), 0);
        check(rst_o == 1'b0, "R2 wrong key ignored while unarmed", int'(rst_o), 0);

        // R2/R3: arm, then service at nominal, low edge and high edge
        bus_write(SVC, KEY);
        idle(PERIOD);
        bus_write(SVC, KEY);
        check(rst_o == 1'b0, "R3 nominal service accepted", int'(rst_o), 0);
        idle(PERIOD - DELTA);
        bus_write(SVC, KEY);
        check(rst_o == 1'b0, "R3 low window edge accepted", int'(rst_o), 0);
        idle(PERIOD + DELTA);
        bus_write(SVC, KEY);
        check(rst_o == 1'b0, "R3 high window edge accepted", int'(rst_o), 0);

        // R9: other addresses while armed; 5+2+12 = 19 ticks, inside the window
        idle(5);
        bus_write(8'h00, 16'h0000);
        bus_write(8'h3D, KEY);
        idle(12);
        bus_write(SVC, KEY);
        check(rst_o == 1'b0, "R9 other addresses no effect", int'(rst_o), 0);

        // R10: no ticks for a long time, then 18 ticks -> in window
        tick = 1'b0;
        idle(200);
        check(rst_o == 1'b0, "R10 counter frozen without tick", int'(rst_o), 0);
        tick = 1'b1;
        idle(18);
        bus_write(SVC, KEY);
        check(rst_o == 1'b0, "R10 only ticks counted", int'(rst_o), 0);

        // R4: one tick below the window
        idle(PERIOD - DELTA - 1);
        expect_bite(2'b01);
        bus_write(SVC, KEY);
        check(rst_o == 1'b1, "R4 early service bites", int'(rst_o), 1);
        check(cause_o == 2'b01, "R4 early cause", int'(cause_o), 1);
        wait_pulse_done();
        idle(TIMEOUT + 20);
        check(rst_o == 1'b0, "R8 unarmed after pulse", int'(rst_o), 0);
        check(cause_o == 2'b01, "R8 cause kept after pulse", int'(cause_o), 1);

        // R5: one tick above the window
        bus_write(SVC, KEY);
        idle(PERIOD + DELTA + 1);
        expect_bite(2'b10);
        bus_write(SVC, KEY);
        check(rst_o == 1'b1, "R5 late service bites", int'(rst_o), 1);
        check(cause_o == 2'b10, "R5 late cause", int'(cause_o), 2);
        wait_pulse_done();

        // R7: wrong value at the service address while armed
        bus_write(SVC, KEY);
        idle(10);
        expect_bite(2'b11);
        bus_write(SVC, 16'h1985);
        check(rst_o == 1'b1, "R7 bad key bites", int'(rst_o), 1);
        check(cause_o == 2'b11, "R7 bad key cause", int'(cause_o), 3);
        wait_pulse_done();

        // R6/R9: still times out after other-address writes
        bus_write(SVC, KEY);
        bus_write(8'h01, 16'hFFFF);
        idle(TIMEOUT - 2);
        check(rst_o == 1'b0, "R6 no bite before timeout", int'(rst_o), 0);
        expect_bite(2'b00);
        idle(1);
        check(rst_o == 1'b1, "R6 timeout bites", int'(rst_o), 1);
        check(cause_o == 2'b00, "R6 timeout cause", int'(cause_o), 0);
        check(rst_o == 1'b1, "R9 not disarmed by other writes", int'(rst_o), 1);
        wait_pulse_done();

        idle(10);
        check(exp_q.size() == 0, "R8 all expected pulses seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule